// File: doc/BRIEF.md
# Memory-Mapped Countdown Watchdog

This block is a watchdog peripheral that sits behind a 128-byte register window with 16-bit registers. Software writes a reload value into the count register and then sets the run bit in the control register. From then on the count drops by one on every coarse tick. The tick is made by dividing the system clock by `TICK_DIV`. At the default setting, one tick is 128 ms of a 250 MHz clock.

Each later write to the count register is a keep-alive. It reloads the count and restarts the tick divider, so the first tick after a reload is always a full period. A read of the count register returns the live number of ticks left.

If software stops servicing the timer and the count reaches zero, the block does two things. It emits a one-cycle timeout pulse and sets a sticky expired flag. To stop the timer, software reads the control register, clears bit 0 and writes the value back.

Top module: `wdog_mmio_top`

## Requirements
- R1: After reset, the count register (byte offset 0x70) and the control register (byte offset 0x72) both read 0x0000. The timeout pulse is low and the expired flag is clear.
- R2: A write to offset 0x70 loads the count. A read of offset 0x70 returns the ticks still remaining.
- R3: All 16 bits of the control register are stored and read back. Only bit 0, the run bit, affects the countdown. Writing 0x0085 starts the timer, and a value with bit 0 clear leaves the count frozen.
- R4: While bit 0 is set and the count is non-zero, the count drops by exactly one every `TICK_DIV` clock cycles. The first decrement comes `TICK_DIV` cycles after the run bit is set or the count is written.
- R5: A write to the count register while the timer runs restarts the countdown from the written value, with a full first tick.
- R6: Rewriting the control register with bit 0 cleared (the read value masked with 0xFE) freezes the count. Setting bit 0 again resumes the count from the frozen value.
- R7: Take the control write that sets bit 0 as cycle 0, with a count of N loaded. The count reaches zero exactly N×`TICK_DIV` cycles later, and the timeout output is high for that one cycle only. After that the count stays at zero and no further pulse occurs.
- R8: The expired flag rises together with the timeout pulse. It stays set until reset, even if the timer is reloaded.
- R9: A read of any offset other than exactly 0x70 or 0x72 returns zero. A write to such an offset changes neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe (no side effects) |
| bus_addr | input | ADDR_W | Byte offset inside the window |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, combinational from the address |
| timeout_pulse | output | 1 | One-cycle pulse when the count reaches zero |
| expired | output | 1 | Sticky expiry flag |

## Verification
Three kinds of internal fault show up at the ports in different ways.
- A prescaler phase error, such as a divider that is not cleared on a reload, moves the zero crossing. The bench samples the timeout pulse in the exact cycle N×`TICK_DIV` after the start, and the cycle before it, so such an error is seen at once.
- A run bit that is decoded wrongly, or a control bit that leaks into the countdown, shows up as a count that changes while it should be frozen. The count is read back after an idle window, which catches this within a few ticks.
- A non-sticky flag or a repeated pulse appears in the cycles right after expiry, and the bench watches every one of those cycles.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   // register selected by the current bus address
   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_COUNT = 2'd1,
      SEL_CTRL  = 2'd2
   } reg_sel_e;

   localparam int unsigned RUN_BIT = 0;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int unsigned ADDR_W   = 7,
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned CNT_OFS  = 'h70,
   parameter int unsigned CTRL_OFS = 'h72
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   input  logic [CNT_W-1:0]  live_count,
   output logic [CNT_W-1:0]  bus_rdata,
   output logic              count_load,
   output logic              run
);
   reg_sel_e         sel;
   logic [CNT_W-1:0] ctrl_q;

   always_comb begin
      if (bus_addr == ADDR_W'(CNT_OFS))       sel = SEL_COUNT;
      else if (bus_addr == ADDR_W'(CTRL_OFS)) sel = SEL_CTRL;
      else                                    sel = SEL_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                         ctrl_q <= '0;
      else if (bus_wr && sel == SEL_CTRL) ctrl_q <= bus_wdata;
   end

   assign count_load = bus_wr && (sel == SEL_COUNT);
   assign run        = ctrl_q[RUN_BIT];

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         unique case (sel)
            SEL_COUNT: bus_rdata = live_count;
            SEL_CTRL:  bus_rdata = ctrl_q;
            default:   bus_rdata = '0;
         endcase
      end
   end

   // R9: a write to any other offset leaves the control register alone
   p_ctrl_untouched_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel != SEL_CTRL) |=> $stable(ctrl_q));
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
   parameter int unsigned TICK_DIV = 32_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic tick
);
   generate
      if (TICK_DIV == 1) begin : g_bypass
         assign tick = run;
      end else begin : g_div
         localparam int unsigned PS_W = $clog2(TICK_DIV);
         localparam logic [PS_W-1:0] LAST = PS_W'(TICK_DIV - 1);
         logic [PS_W-1:0] ps_q;

         always_ff @(posedge clk) begin
            if (!rst_n)                 ps_q <= '0;
            else if (restart || !run)   ps_q <= '0;
            else if (ps_q == LAST)      ps_q <= '0;
            else                        ps_q <= ps_q + 1'b1;
         end

         assign tick = run && (ps_q == LAST);

         // R4: ticks are never back to back when the divider is active
         p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             run,
   input  logic             tick,
   output logic [CNT_W-1:0] count,
   output logic             timeout_pulse,
   output logic             expired
);
   logic [CNT_W-1:0] cnt_q;
   logic             pulse_q, exp_q;
   logic             step, fire;

   assign step = !load && run && tick && (cnt_q != '0);
   assign fire = step && (cnt_q == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         pulse_q <= 1'b0;
         exp_q   <= 1'b0;
      end else begin
         if (load)      cnt_q <= load_val;
         else if (step) cnt_q <= cnt_q - 1'b1;
         pulse_q <= fire;
         exp_q   <= exp_q | fire;
      end
   end

   assign count         = cnt_q;
   assign timeout_pulse = pulse_q;
   assign expired       = exp_q;

   // R4: a tick with no competing load removes exactly one
   p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
   // R6: with run clear and no load the count is frozen
   p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load) |=> $stable(cnt_q));
   // R7: zero holds and the pulse lasts one cycle
   p_zero_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !load) |=> (cnt_q == '0));
   p_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_pulse |=> !timeout_pulse);
   // R8: flag accompanies the pulse and never drops
   p_flag_with_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_pulse |-> expired);
   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      expired |=> expired);
endmodule

// File: rtl/wdog_mmio_top.sv
module wdog_mmio_top #(
   parameter int unsigned WINDOW_BYTES = 128,
   parameter int unsigned CNT_W        = 16,
   parameter int unsigned CNT_OFS      = 'h70,
   parameter int unsigned CTRL_OFS     = 'h72,
   parameter int unsigned TICK_DIV     = 32_000_000,
   localparam int unsigned ADDR_W      = $clog2(WINDOW_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   output logic              timeout_pulse,
   output logic              expired
);
   if (TICK_DIV < 1) begin : g_bad_div
      $error("TICK_DIV must be at least 1");
   end
   if (CNT_OFS == CTRL_OFS) begin : g_bad_ofs
      $error("register offsets must differ");
   end
   if (CNT_OFS + 2 > WINDOW_BYTES || CTRL_OFS + 2 > WINDOW_BYTES) begin : g_bad_win
      $error("register offsets must fit in the window");
   end
   if (CNT_W < 2) begin : g_bad_w
      $error("CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] live_count;
   logic             count_load, run, tick;

   wdog_regs #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CNT_OFS(CNT_OFS), .CTRL_OFS(CTRL_OFS)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .live_count(live_count),
      .bus_rdata(bus_rdata), .count_load(count_load), .run(run)
   );

   wdog_prescaler #(.TICK_DIV(TICK_DIV)) presc_i (
      .clk(clk), .rst_n(rst_n), .run(run), .restart(count_load), .tick(tick)
   );

   wdog_countdown #(.CNT_W(CNT_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .load(count_load), .load_val(bus_wdata),
      .run(run), .tick(tick), .count(live_count),
      .timeout_pulse(timeout_pulse), .expired(expired)
   );
endmodule

// File: tb/wdog_mmio_top_tb.sv
`timescale 1ns/100ps
module wdog_mmio_top_tb_top;
   localparam int unsigned D = 4;
   localparam logic [6:0] A_CNT  = 7'h70;
   localparam logic [6:0] A_CTRL = 7'h72;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [6:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        timeout_pulse, expired;
   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   wdog_mmio_top #(.TICK_DIV(D)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .timeout_pulse(timeout_pulse), .expired(expired)
   );

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [6:0] a, logic [15:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); #0.5;
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [6:0] a, output logic [15:0] d);
      bus_rd = 1'b1; bus_addr = a;
      #0.1; d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic cyc(int n);
      repeat (n) begin @(negedge clk); #0.5; end
   endtask

   task automatic t_reset;
      logic [15:0] v;
      rd(A_CNT, v);  chk("R1 count", v, 16'h0);
      rd(A_CTRL, v); chk("R1 ctrl", v, 16'h0);
      chk("R1 pulse", {15'b0, timeout_pulse}, 16'h0);
      chk("R1 expired", {15'b0, expired}, 16'h0);
   endtask

   task automatic t_unmapped;
      logic [15:0] v;
      wr(7'h10, 16'hFFFF);
      wr(7'h71, 16'hFFFF);
      wr(7'h73, 16'hFFFF);
      rd(7'h10, v);  chk("R9 read 0x10", v, 16'h0);
      rd(7'h7E, v);  chk("R9 read 0x7E", v, 16'h0);
      rd(A_CNT, v);  chk("R9 count untouched", v, 16'h0);
      rd(A_CTRL, v); chk("R9 ctrl untouched", v, 16'h0);
   endtask

   task automatic t_ctrl_bits;
      logic [15:0] v;
      wr(A_CNT, 16'd3);
      rd(A_CNT, v);  chk("R2 load", v, 16'd3);
      wr(A_CTRL, 16'hA5FE);
      cyc(5 * D);
      rd(A_CTRL, v); chk("R3 readback", v, 16'hA5FE);
      rd(A_CNT, v);  chk("R3 no run", v, 16'd3);
   endtask

   task automatic t_expire;
      logic [15:0] v;
      int bad = 0;
      wr(A_CNT, 16'd5);
      wr(A_CTRL, 16'h0085);
      cyc(5 * D - 1);
      rd(A_CNT, v);  chk("R7 one left", v, 16'd1);
      chk("R7 no early pulse", {15'b0, timeout_pulse}, 16'h0);
      chk("R8 not yet expired", {15'b0, expired}, 16'h0);
      cyc(1);
      rd(A_CNT, v);  chk("R7 zero", v, 16'd0);
      chk("R7 pulse", {15'b0, timeout_pulse}, 16'h1);
      chk("R8 expired", {15'b0, expired}, 16'h1);
      for (int i = 0; i < 12; i++) begin
         cyc(1);
         if (timeout_pulse !== 1'b0) bad++;
      end
      chk("R7 single pulse", 16'(bad), 16'h0);
      rd(A_CNT, v);  chk("R7 hold zero", v, 16'd0);
   endtask

   task automatic t_sticky;
      logic [15:0] v;
      wr(A_CNT, 16'd9);
      rd(A_CNT, v);  chk("R2 reload", v, 16'd9);
      chk("R8 sticky after reload", {15'b0, expired}, 16'h1);
      cyc(D);
      rd(A_CNT, v);  chk("R4 one tick", v, 16'd8);
      chk("R8 sticky running", {15'b0, expired}, 16'h1);
   endtask

   task automatic t_keepalive;
      logic [15:0] v;
      cyc(2 * D);
      rd(A_CNT, v);  chk("R4 two ticks", v, 16'd6);
      wr(A_CNT, 16'd10);
      rd(A_CNT, v);  chk("R5 ping value", v, 16'd10);
      cyc(D - 1);
      rd(A_CNT, v);  chk("R5 full first tick", v, 16'd10);
      cyc(1);
      rd(A_CNT, v);  chk("R5 after tick", v, 16'd9);
   endtask

   task automatic t_stop;
      logic [15:0] v, c;
      rd(A_CTRL, v); chk("R3 ctrl read", v, 16'h0085);
      wr(A_CTRL, v & 16'h00FE);
      rd(A_CNT, c);
      cyc(6 * D);
      rd(A_CNT, v);  chk("R6 frozen", v, c);
      rd(A_CTRL, v); chk("R6 ctrl stopped", v, 16'h0084);
      wr(A_CTRL, 16'h0085);
      cyc(D - 1);
      rd(A_CNT, v);  chk("R6 resume wait", v, c);
      cyc(1);
      rd(A_CNT, v);  chk("R6 resumed", v, c - 16'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #0.5;
      t_reset();
      t_unmapped();
      t_ctrl_bits();
      t_expire();
      t_sticky();
      t_keepalive();
      t_stop();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule